// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block takes a continuous serial control stream made of three wires: a bit clock, a data line and a frame-sync line. It decodes the stream into one set of control fields. All three wires are asynchronous to the system clock. They pass through synchronisers, and their edges are found in the system clock domain. The system clock must run several times faster than the bit clock.

A falling edge on the frame-sync line opens a frame. After that edge the block shifts in 49 data bits, most significant bit first, one on each rising edge of the bit clock. It then splits the word into six fields of unequal width: a push-to-talk flag, an address, a 32-bit frequency in hertz, a band code, seven open-collector output bits and a mode flag.

The fields are held in output registers. They change only when a frame completes. A one-cycle strobe marks each change. A frame cut short by a new sync edge is dropped. Bits that follow the 49th bit are ignored until the next sync edge.

Top module: `cmd_frame_rx`

## Requirements
- R1: Data bits are ignored until a falling edge of `fsync_i` has been seen. Each such falling edge starts a new frame with its bit count at zero.
- R2: Within a frame, `bdata_i` is sampled on each rising edge of `bclk_i`. The first bit sampled is the most significant bit (bit 48) of the 49-bit frame word.
- R3: The field split of the frame word is as follows. Bit 48 drives `ptt_o`. Bits 47:44 drive `addr_o`. Bits 11:8 drive `band_o`. Bits 7:1 drive `oc_o`, with bit 7 at `oc_o[6]`. Bit 0 drives `mode_o`.
- R4: Bits 43:12 of the frame word appear on `freq_o` as a 32-bit unsigned value, with bit 43 as its most significant bit.
- R5: Each frame that receives all 49 bits produces exactly one `valid_o` pulse, one system clock cycle long. The new field values are present in that same cycle.
- R6: The output fields change only in a cycle where `valid_o` is high. Otherwise they hold their last values.
- R7: A frame that gets fewer than 49 bits before the next falling edge of `fsync_i` gives no `valid_o` pulse and leaves the fields unchanged.
- R8: Rising bit-clock edges after the 49th bit and before the next `fsync_i` falling edge are ignored. They give no pulse and change no field.
- R9: While `rst` is high, and on the first cycle after it, `valid_o` is 0 and every output field is 0.
- R10: The system clock edge that first samples the 49th rising edge of `bclk_i` is counted as edge 0. `valid_o` is high during the cycle that follows system clock edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| bdata_i | input | 1 | Serial data, sampled on rising `bclk_i` |
| fsync_i | input | 1 | Frame sync, falling edge starts a frame |
| ptt_o | output | 1 | Push-to-talk flag |
| addr_o | output | 4 | Address field |
| freq_o | output | 32 | Frequency in hertz, unsigned |
| band_o | output | 4 | Band code |
| oc_o | output | 7 | Open-collector output bits |
| mode_o | output | 1 | Mode flag |
| valid_o | output | 1 | One-cycle strobe on field update |

## Verification
The bound assertions check the following on every cycle:
- the strobe lasts exactly one cycle;
- every completed frame leads to a strobe in the next cycle;
- the fields move only under the strobe;
- the bit count never goes past the frame length;
- a sync edge is never followed at once by a completion.

The field split, the most-significant-bit-first order, the dropping of a truncated frame, the ignoring of trailing bits and the exact latency from the pins are shown only by the bench. Its behavioural model replays the synchroniser delay from a history of pin samples and rebuilds the frame word, and the bench compares against that model on every clock.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  typedef enum logic [1:0] {
    FR_WAIT = 2'd0,
    FR_RECV = 2'd1,
    FR_FULL = 2'd2
  } fr_state_e;

  function automatic int frame_bits(input int addr_w, input int freq_w,
                                    input int band_w, input int oc_w);
    return 2 + addr_w + freq_w + band_w + oc_w;
  endfunction

endpackage

// File: rtl/cfr_sync.sv
module cfr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfr_edge.sv
module cfr_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/cfr_framer.sv
module cfr_framer #(
  parameter int FRAME_BITS = 49,
  localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  bit_stb,
  input  logic                  bit_val,
  output logic [FRAME_BITS-1:0] word,
  output logic [CNT_W-1:0]      cnt,
  output logic                  done
);
  import cfr_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  fr_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= FR_WAIT;
      cnt  <= '0;
      word <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st  <= FR_RECV;
        cnt <= '0;
      end else if (bit_stb && st == FR_RECV) begin
        word <= {word[FRAME_BITS-2:0], bit_val};
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) begin
          st   <= FR_FULL;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
  parameter int ADDR_W      = 4,
  parameter int FREQ_W      = 32,
  parameter int BAND_W      = 4,
  parameter int OC_W        = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_i,
  input  logic              bdata_i,
  input  logic              fsync_i,
  output logic              ptt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic [BAND_W-1:0] band_o,
  output logic [OC_W-1:0]   oc_o,
  output logic              mode_o,
  output logic              valid_o
);
  localparam int FRAME_BITS = cfr_pkg::frame_bits(ADDR_W, FREQ_W, BAND_W, OC_W);
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int OC_LO      = 1;
  localparam int BAND_LO    = OC_LO + OC_W;
  localparam int FREQ_LO    = BAND_LO + BAND_W;
  localparam int ADDR_LO    = FREQ_LO + FREQ_W;
  localparam int PTT_POS    = ADDR_LO + ADDR_W;

  logic [2:0]            pins_s;
  logic [1:0]            rise_v, fall_v;
  logic                  fs_fall;
  logic [FRAME_BITS-1:0] word;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] out_q;

  cfr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({fsync_i, bdata_i, bclk_i}),
    .q   (pins_s)
  );

  cfr_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({pins_s[2], pins_s[0]}),
    .rise (rise_v),
    .fall (fall_v)
  );

  assign fs_fall = fall_v[1];

  cfr_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
    .clk     (clk),
    .rst     (rst),
    .start   (fs_fall),
    .bit_stb (rise_v[0]),
    .bit_val (pins_s[1]),
    .word    (word),
    .cnt     (bit_cnt),
    .done    (frame_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= frame_done;
      if (frame_done) out_q <= word;
    end
  end

  assign ptt_o  = out_q[PTT_POS];
  assign addr_o = out_q[ADDR_LO +: ADDR_W];
  assign freq_o = out_q[FREQ_LO +: FREQ_W];
  assign band_o = out_q[BAND_LO +: BAND_W];
  assign oc_o   = out_q[OC_LO +: OC_W];
  assign mode_o = out_q[0];
endmodule

// File: rtl/cmd_frame_rx_chk.sv
module cmd_frame_rx_chk #(
  parameter int FRAME_BITS = 49,
  parameter int CNT_W      = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  valid_o,
  input logic                  frame_done,
  input logic                  fs_fall,
  input logic [CNT_W-1:0]      bit_cnt,
  input logic [FRAME_BITS-1:0] out_q
);
  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R5
  done_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> valid_o);

  // R6
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_q) |-> valid_o);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_BITS));

  // R2
  full_count_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> bit_cnt == CNT_W'(FRAME_BITS));

  // R7
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    fs_fall |=> !frame_done);
endmodule

bind cmd_frame_rx cmd_frame_rx_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .valid_o    (valid_o),
  .frame_done (frame_done),
  .fs_fall    (fs_fall),
  .bit_cnt    (bit_cnt),
  .out_q      (out_q)
);

// File: tb/tb_cmd_frame_rx.sv
`timescale 1ns/1ps
module tb_cmd_frame_rx;
  localparam int NB   = 49;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk_i = 1'b0, bdata_i = 1'b0, fsync_i = 1'b1;
  logic ptt_o, mode_o, valid_o;
  logic [3:0] addr_o, band_o;
  logic [31:0] freq_o;
  logic [6:0] oc_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  cmd_frame_rx dut (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .bdata_i(bdata_i), .fsync_i(fsync_i),
    .ptt_o(ptt_o), .addr_o(addr_o), .freq_o(freq_o), .band_o(band_o),
    .oc_o(oc_o), .mode_o(mode_o), .valid_o(valid_o)
  );

  // Behavioural reference: pin history, then frame rebuilt bit by bit.
  logic hc [4], hd [4], hf [4];
  bit          m_open;
  int          m_bits;
  logic [48:0] m_word;
  bit          m_done;
  bit          e_valid;
  logic [48:0] e_word;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin hc[i] = 0; hd[i] = 0; hf[i] = 0; end
      m_open = 0; m_bits = 0; m_word = '0; m_done = 0;
      e_valid = 0; e_word = '0;
    end else begin
      for (int i = 3; i > 0; i--) begin hc[i] = hc[i-1]; hd[i] = hd[i-1]; hf[i] = hf[i-1]; end
      hc[0] = bclk_i; hd[0] = bdata_i; hf[0] = fsync_i;
      e_valid = m_done;
      if (m_done) e_word = m_word;
      m_done = 0;
      if (hf[3] && !hf[2]) begin
        m_open = 1; m_bits = 0;
      end else if (hc[2] && !hc[3] && m_open) begin
        m_word = {m_word[47:0], hd[2]};
        m_bits++;
        if (m_bits == NB) begin m_done = 1; m_open = 0; end
      end
    end
  end

  function automatic logic [48:0] got_word();
    return {ptt_o, addr_o, freq_o, band_o, oc_o, mode_o};
  endfunction

  bit prev_valid = 0;
  always @(negedge clk) begin
    if (!rst && !done_run) begin
      checks++;
      if (valid_o !== e_valid) begin
        errors++;
        $display("FAIL R10 cycle model: valid_o=%0b expected %0b at %0t", valid_o, e_valid, $time);
      end
      checks++;
      if (got_word() !== e_word) begin
        errors++;
        $display("FAIL R6 cycle model: fields=%h expected %h at %0t", got_word(), e_word, $time);
      end
      if (valid_o && prev_valid) begin
        errors++;
        $display("FAIL R5 strobe width: actual 2+ cycles expected 1");
      end
      if (valid_o) pulses++;
    end
    prev_valid = valid_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bdata_i = b; bclk_i = 1'b0;
    wait_clk(HALF);
    bclk_i = 1'b1;
    wait_clk(HALF);
    bclk_i = 1'b0;
  endtask

  task automatic send_frame(input logic [48:0] w, input int nbits, input int extra);
    @(negedge clk); fsync_i = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) send_bit(w[48-i]);
    for (int i = 0; i < extra; i++) send_bit(i[0] ^ 1'b1);
    wait_clk(HALF);
    fsync_i = 1'b1;
    wait_clk(8);
  endtask

  task automatic check_fields(input string tag, input logic [48:0] w);
    chk({tag, " R3 ptt"},  64'(ptt_o),  64'(w[48]));
    chk({tag, " R3 addr"}, 64'(addr_o), 64'(w[47:44]));
    chk({tag, " R4 freq"}, 64'(freq_o), 64'(w[43:12]));
    chk({tag, " R3 band"}, 64'(band_o), 64'(w[11:8]));
    chk({tag, " R3 oc"},   64'(oc_o),   64'(w[7:1]));
    chk({tag, " R3 mode"}, 64'(mode_o), 64'(w[0]));
  endtask

  initial begin
    #1_000_000;
    if (!done_run) begin
      done_run = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [48:0] wa, wb, wc, wl;
    int p0;
    wa = {1'b1, 4'hA, 32'd14_074_000, 4'h5, 7'b1010011, 1'b0};
    wb = {1'b0, 4'h3, 32'hDEAD_BEEF, 4'hC, 7'b0110100, 1'b1};
    wc = {49{1'b1}};

    wait_clk(4);
    // R9 reset state
    chk("R9 valid in reset", 64'(valid_o), 64'd0);
    chk("R9 fields in reset", 64'(got_word()), 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R9 valid after reset", 64'(valid_o), 64'd0);
    chk("R9 fields after reset", 64'(got_word()), 64'd0);

    // R1: bits with no sync edge
    for (int i = 0; i < 60; i++) send_bit(1'b1);
    wait_clk(8);
    chk("R1 no frame without sync", 64'(pulses), 64'd0);
    chk("R1 fields untouched", 64'(got_word()), 64'd0);

    // R2 R3 R4 R5: distinct frames
    p0 = pulses; send_frame(wa, NB, 0);
    chk("R5 one pulse frame A", 64'(pulses - p0), 64'd1);
    check_fields("A", wa);
    p0 = pulses; send_frame(wb, NB, 0);
    chk("R5 one pulse frame B", 64'(pulses - p0), 64'd1);
    check_fields("B", wb);
    p0 = pulses; send_frame(wc, NB, 0);
    chk("R2 all-ones frame", 64'(pulses - p0), 64'd1);
    check_fields("C", wc);
    p0 = pulses; send_frame('0, NB, 0);
    check_fields("zeros", 49'd0);
    wl = 49'h1;
    p0 = pulses; send_frame(wl, NB, 0);
    chk("R2 last bit is lsb", 64'(mode_o), 64'd1);

    // R7: truncated frame
    p0 = pulses; send_frame(wb, 30, 0);
    chk("R7 no pulse on short frame", 64'(pulses - p0), 64'd0);
    check_fields("R7 hold", wl);
    p0 = pulses; send_frame(wa, NB - 1, 0);
    chk("R7 48 bits no pulse", 64'(pulses - p0), 64'd0);
    check_fields("R7 hold2", wl);

    // R8: trailing bits ignored
    p0 = pulses; send_frame(wb, NB, 12);
    chk("R8 one pulse with trailing bits", 64'(pulses - p0), 64'd1);
    check_fields("R8", wb);

    // R6: hold across idle
    wait_clk(200);
    check_fields("R6 idle hold", wb);
    chk("R6 no spurious pulse", 64'(pulses - p0), 64'd1);

    // R1: frame restarts after a short frame directly
    p0 = pulses; send_frame(wa, 20, 0); send_frame(wc, NB, 0);
    chk("R1 restart after short", 64'(pulses - p0), 64'd1);
    check_fields("R1 restart", wc);

    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule